// File: doc/BRIEF.md
# Byte FIFO with Programmable Water-Level Alerts

This block is a byte-wide first-in first-out buffer that sits between a host register port and an internal protocol engine. Either side can put bytes in or take bytes out. The host writes and reads through a single data register. Its push and pop strobes are merged with the engine's own push and pop handshake. A host push takes precedence over an engine push in the same cycle. Both sides see the same registered output byte.

The host can read the current fill count at any time. Two warning flags come from one programmable water level: near-full means that few free slots remain, and near-empty means that few bytes remain. A push into a full buffer is dropped and latches an overflow error flag. That flag stays set until the host clears it or flushes the buffer. A flush strobe empties the buffer in one cycle.

Top module: `byte_fifo_wm`

## Requirements
- R1: After a synchronous active-low reset, the fill count is 0, near-empty is 1, near-full is 0, the overflow flag is 0, the water level reads 8 and the output byte is 0x00.
- R2: Bytes leave in the order they were accepted. The output byte takes the popped value in the cycle after the pop strobe.
- R3: The fill count is a 7-bit value from 0 to 64. An accepted push raises it by one and an accepted pop lowers it by one.
- R4: Near-full is 1 exactly when (64 − fill count) ≤ water level.
- R5: Near-empty is 1 exactly when fill count ≤ water level.
- R6: A water-level write stores bits [5:0] of the written byte. Bits [7:6] are ignored.
- R7: A push while the fill count is 64 is dropped and sets the overflow flag. This holds even when a pop is accepted in the same cycle. The overflow flag then stays at 1.
- R8: The overflow-clear strobe resets the overflow flag. If an overflow occurs in the same cycle, the set wins.
- R9: A flush strobe sets the fill count to 0 and clears the overflow flag in one cycle. It overrides any push or pop in that cycle and leaves the output byte unchanged.
- R10: A pop while the fill count is 0 leaves the output byte and the fill count unchanged and sets no error.
- R11: A push and a pop in the same cycle with 0 < fill count < 64 leave the fill count unchanged.
- R12: When the host and the engine push in the same cycle, only the host byte is stored. The engine byte is dropped and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_push | input | 1 | Host write to the data register |
| host_wdata | input | 8 | Host byte to store |
| host_pop | input | 1 | Host read of the data register |
| eng_push | input | 1 | Engine push strobe |
| eng_wdata | input | 8 | Engine byte to store |
| eng_pop | input | 1 | Engine pop strobe |
| rd_data | output | 8 | Last byte popped, shared by both sides |
| flush | input | 1 | Empties the buffer and clears overflow |
| ovf_clr | input | 1 | Clears the overflow flag |
| wl_wr | input | 1 | Water-level write strobe |
| wl_wdata | input | 8 | Water-level write byte (bits [5:0] used) |
| water_level | output | 6 | Current water level |
| fill_level | output | 7 | Number of stored bytes |
| near_full | output | 1 | Free space at or below the water level |
| near_empty | output | 1 | Fill count at or below the water level |
| ovf_err | output | 1 | Sticky overflow error |

## Verification
The bench builds the block with its default parameters: 64 entries of 8 bits and a 6-bit water level. With these values a fill of exactly 64, the wrap of both pointers and the largest water level, 63, can all be reached in a few hundred cycles. It drives the buffer to full and then beyond, then drains it past empty. It applies simultaneous push and pop at full, at empty and part-way, and overlaps flush and clear with overflow. It sweeps the water level through 0, 8, 32 and 63, so that both alert thresholds are crossed in both directions.

// File: rtl/fifo_wm_pkg.sv
// Package of shared defaults for the water-level FIFO.
// Assumes the depth is a power of two so that pointers wrap naturally.
package fifo_wm_pkg;
    parameter int unsigned DEF_DEPTH    = 64;
    parameter int unsigned DEF_WIDTH    = 8;
    parameter int unsigned DEF_WL_W     = 6;
    parameter int unsigned DEF_WL_RESET = 8;
endpackage

// File: rtl/fifo_wm_ctrl.sv
// Pointer, fill-count and overflow control for the FIFO.
// Decides which pushes and pops are accepted from the count at the start of the cycle.
// Flush has top priority. Assumes DEPTH is a power of two.
module fifo_wm_ctrl #(
    parameter int unsigned DEPTH = fifo_wm_pkg::DEF_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic          ovf_clr,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [LW-1:0] level,
    output logic          ovf
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    // Acceptance decisions, taken from the count at the start of the cycle.
    always_comb begin
        push_ok = push && !flush && (level != FULL);
        pop_ok  = pop  && !flush && (level != '0);
    end

    // Pointer and level update, with flush overriding both.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Sticky overflow flag: a set beats a clear, and a flush clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)             ovf <= 1'b0;
        else if (push && level == FULL)  ovf <= 1'b1;
        else if (ovf_clr)                ovf <= 1'b0;
    end

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL);
    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !ovf));
    // R7
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush && level == FULL) |=> ovf);
    // R11
    balanced_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush && level != '0 && level != FULL) |=> $stable(level));
endmodule

// File: rtl/fifo_wm_store.sv
// Byte storage with a registered read port.
// A write happens on an accepted push. The output register loads on an accepted pop and otherwise holds.
module fifo_wm_store #(
    parameter int unsigned DEPTH = fifo_wm_pkg::DEF_DEPTH,
    parameter int unsigned WIDTH = fifo_wm_pkg::DEF_WIDTH,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Array write on an accepted push.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Output byte register: loads on an accepted pop, otherwise keeps its value.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/fifo_wm_alerts.sv
// Near-full and near-empty comparators driven by the one water level.
// Purely combinational. Assumes level never exceeds DEPTH.
module fifo_wm_alerts #(
    parameter int unsigned DEPTH = fifo_wm_pkg::DEF_DEPTH,
    parameter int unsigned WL_W  = fifo_wm_pkg::DEF_WL_W,
    localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   level,
    input  logic [WL_W-1:0] wl,
    output logic            near_full,
    output logic            near_empty
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);
    logic [LW-1:0] free_slots;
    logic [LW-1:0] wl_ext;

    // Free-space computation and the two threshold compares.
    always_comb begin
        free_slots = FULL - level;
        wl_ext     = LW'(wl);
        near_full  = free_slots <= wl_ext;
        near_empty = level <= wl_ext;
    end

    // R5
    empty_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0) |-> near_empty);
    // R4
    full_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == FULL) |-> near_full);
endmodule

// File: rtl/byte_fifo_wm.sv
// Top of the water-level FIFO.
// Merges the host and engine strobes, with the host winning a push tie, and holds the water-level register.
// Ties together the control, storage and alert logic.
module byte_fifo_wm #(
    parameter int unsigned DEPTH    = fifo_wm_pkg::DEF_DEPTH,
    parameter int unsigned WIDTH    = fifo_wm_pkg::DEF_WIDTH,
    parameter int unsigned WL_W     = fifo_wm_pkg::DEF_WL_W,
    parameter int unsigned WL_RESET = fifo_wm_pkg::DEF_WL_RESET,
    localparam int unsigned AW      = $clog2(DEPTH),
    localparam int unsigned LW      = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_push,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             host_pop,
    input  logic             eng_push,
    input  logic [WIDTH-1:0] eng_wdata,
    input  logic             eng_pop,
    output logic [WIDTH-1:0] rd_data,
    input  logic             flush,
    input  logic             ovf_clr,
    input  logic             wl_wr,
    input  logic [7:0]       wl_wdata,
    output logic [WL_W-1:0]  water_level,
    output logic [LW-1:0]    fill_level,
    output logic             near_full,
    output logic             near_empty,
    output logic             ovf_err
);
    logic             push_req, pop_req, push_ok, pop_ok;
    logic [WIDTH-1:0] push_data;
    logic [AW-1:0]    wr_ptr, rd_ptr;

    // Source merge: the host byte wins a simultaneous push.
    always_comb begin
        push_req  = host_push | eng_push;
        pop_req   = host_pop  | eng_pop;
        push_data = host_push ? host_wdata : eng_wdata;
    end

    // Water-level register: only the low WL_W bits of the write byte are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)     water_level <= WL_W'(WL_RESET);
        else if (wl_wr) water_level <= wl_wdata[WL_W-1:0];
    end

    fifo_wm_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push(push_req), .pop(pop_req),
        .flush(flush), .ovf_clr(ovf_clr), .push_ok(push_ok), .pop_ok(pop_ok),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(fill_level), .ovf(ovf_err)
    );

    fifo_wm_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(push_ok), .waddr(wr_ptr), .wdata(push_data),
        .re(pop_ok), .raddr(rd_ptr), .rdata(rd_data)
    );

    fifo_wm_alerts #(.DEPTH(DEPTH), .WL_W(WL_W)) u_alerts (
        .clk(clk), .rst_n(rst_n), .level(fill_level), .wl(water_level),
        .near_full(near_full), .near_empty(near_empty)
    );

    // R10
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !flush && fill_level == '0) |=> ($stable(rd_data) && fill_level == '0));
    // R9
    flush_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $stable(rd_data));
    // R6
    wl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wl_wr |=> (water_level == $past(wl_wdata[WL_W-1:0])));
endmodule

// File: tb/tb_byte_fifo_wm.sv
// Cycle-by-cycle reference-model bench for byte_fifo_wm.
module tb_byte_fifo_wm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_push = 0, host_pop = 0, eng_push = 0, eng_pop = 0;
    logic [7:0] host_wdata = 0, eng_wdata = 0, wl_wdata = 0;
    logic       flush = 0, ovf_clr = 0, wl_wr = 0;
    logic [7:0] rd_data;
    logic [5:0] water_level;
    logic [6:0] fill_level;
    logic       near_full, near_empty, ovf_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    byte unsigned q[$];
    byte unsigned m_rd = 0;
    bit           m_ovf = 0;
    int           m_wl = 8;

    always #10 clk = ~clk;

    byte_fifo_wm dut (
        .clk(clk), .rst_n(rst_n), .host_push(host_push), .host_wdata(host_wdata),
        .host_pop(host_pop), .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
        .rd_data(rd_data), .flush(flush), .ovf_clr(ovf_clr), .wl_wr(wl_wr),
        .wl_wdata(wl_wdata), .water_level(water_level), .fill_level(fill_level),
        .near_full(near_full), .near_empty(near_empty), .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        int lv = q.size();
        chk(fill_level == 7'(lv), "R3 fill level", int'(fill_level), lv);
        chk(rd_data == m_rd, "R2 output byte", int'(rd_data), int'(m_rd));
        chk(ovf_err == m_ovf, "R7 overflow flag", int'(ovf_err), int'(m_ovf));
        chk(water_level == 6'(m_wl), "R6 water level", int'(water_level), m_wl);
        chk(near_full == ((64 - lv) <= m_wl), "R4 near-full", int'(near_full), int'((64 - lv) <= m_wl));
        chk(near_empty == (lv <= m_wl), "R5 near-empty", int'(near_empty), int'(lv <= m_wl));
    endtask

    // One clock: advance the model at the edge, compare at the falling edge.
    task automatic tick();
        bit push, pop, push_ok, pop_ok;
        byte unsigned pd;
        @(posedge clk);
        push = host_push || eng_push;
        pop  = host_pop || eng_pop;
        pd   = host_push ? host_wdata : eng_wdata;
        if (wl_wr) m_wl = int'(wl_wdata[5:0]);
        if (flush) begin
            q.delete();
            m_ovf = 0;
        end else begin
            push_ok = push && q.size() < 64;
            pop_ok  = pop && q.size() > 0;
            if (push && !push_ok) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            if (pop_ok) m_rd = q.pop_front();
            if (push_ok) q.push_back(pd);
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        host_push = 0; host_pop = 0; eng_push = 0; eng_pop = 0;
        flush = 0; ovf_clr = 0; wl_wr = 0;
    endtask

    task automatic set_wl(input logic [7:0] v);
        idle(); wl_wr = 1; wl_wdata = v; tick(); idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(fill_level == 0 && near_empty && !near_full && !ovf_err, "R1 reset flags", int'(fill_level), 0);
        chk(water_level == 6'd8 && rd_data == 8'h00, "R1 reset wl/data", int'(water_level), 8);
        // R10 pop on empty
        idle(); host_pop = 1; tick(); eng_pop = 1; tick(); idle();
        chk(rd_data == 0 && !ovf_err && fill_level == 0, "R10 empty pop", int'(rd_data), 0);
        // R6 upper bits ignored
        set_wl(8'hC5);
        chk(water_level == 6'd5, "R6 reserved bits", int'(water_level), 5);
        set_wl(8'd8);
        // Fill to full, alternating sources (R2, R3, R4)
        for (int i = 0; i < 64; i++) begin
            idle();
            if (i % 2 == 0) begin host_push = 1; host_wdata = 8'(i + 1); end
            else begin eng_push = 1; eng_wdata = 8'(i + 1); end
            tick();
        end
        idle();
        chk(fill_level == 7'd64 && near_full && !ovf_err, "R3 full count", int'(fill_level), 64);
        // R7 push into full, with a pop in the same cycle and a clear (R8 set wins)
        host_push = 1; host_wdata = 8'hEE; host_pop = 1; ovf_clr = 1; tick(); idle();
        chk(ovf_err && fill_level == 7'd63, "R7 full push+pop", int'(fill_level), 63);
        chk(rd_data == 8'd1, "R2 first byte out", int'(rd_data), 1);
        tick();
        chk(ovf_err, "R7 sticky", int'(ovf_err), 1);
        ovf_clr = 1; tick(); idle();
        chk(!ovf_err, "R8 clear", int'(ovf_err), 0);
        // R11 balanced push/pop mid-fill
        for (int i = 0; i < 10; i++) begin
            idle(); eng_push = 1; eng_wdata = 8'(100 + i); eng_pop = 1; tick();
            chk(fill_level == 7'd63, "R11 balanced", int'(fill_level), 63);
        end
        // Drain with water level sweeps (R4, R5)
        set_wl(8'd32);
        for (int i = 0; i < 70; i++) begin
            idle();
            if (i % 3 == 0) eng_pop = 1; else host_pop = 1;
            if (i == 40) set_wl(8'd63);
            tick();
        end
        idle();
        chk(fill_level == 0 && near_empty, "R5 drained", int'(fill_level), 0);
        // R12 simultaneous host and engine push
        set_wl(8'd0);
        host_push = 1; host_wdata = 8'hA5; eng_push = 1; eng_wdata = 8'h5A; tick(); idle();
        chk(fill_level == 1 && !ovf_err, "R12 one byte stored", int'(fill_level), 1);
        eng_pop = 1; tick(); idle();
        chk(rd_data == 8'hA5, "R12 host byte kept", int'(rd_data), 8'hA5);
        // R9 flush overriding push/pop, clearing overflow
        for (int i = 0; i < 66; i++) begin host_push = 1; host_wdata = 8'(i ^ 8'h3C); tick(); end
        idle();
        chk(ovf_err, "R7 overflow before flush", int'(ovf_err), 1);
        flush = 1; host_push = 1; eng_pop = 1; tick(); idle();
        chk(fill_level == 0 && !ovf_err && rd_data == 8'hA5, "R9 flush", int'(fill_level), 0);
        // Pseudo-random mix, model compared every cycle
        set_wl(8'd8);
        begin
            logic [15:0] lf = 16'hACE1;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                idle();
                host_push = lf[0] & lf[1]; host_wdata = lf[15:8];
                eng_push = lf[2];          eng_wdata = lf[7:0];
                host_pop = lf[3] & lf[4];  eng_pop = lf[5] & ~lf[6];
                flush = (lf[11:4] == 8'h00);
                ovf_clr = (lf[9:6] == 4'h0);
                if (lf[12:5] == 8'hFF) begin wl_wr = 1; wl_wdata = lf[7:0]; end
                tick();
            end
        end
        idle(); tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule